// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers interrupt requests from six sources: one external pin event, one pin-change event and four timer events. Each source has a latched flag, its own enable bit and a shared global enable. From these the block selects one request and starts a fixed entry sequence for a small CPU sequencer. During that sequence it strobes pushes of the program counter and presents the vector address of the chosen source. It also drives a matching return sequence that pops the counter and turns the global enable back on.

The CPU tells the block when an instruction has completed (`insn_done`). A multi-cycle instruction raises it only in its final cycle, so an interrupt is never taken in the middle of one. The CPU also signals when the completing instruction is a return-from-interrupt (`reti_done`). Software clears flags by writing ones to the flag-clear inputs. Software sets or clears the global enable through two strobes.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When several enabled flags are pending at a boundary, only the source with the lowest vector address is taken, and every other flag stays set.
- R2: Vector addresses are: external pin 1, pin change 2, timer-1 compare A 3, timer-1 compare B 4, timer-1 overflow 5, timer-0 overflow 6. In the 8-bit timer flag, event, mask and clear vectors, compare A is bit 6, compare B is bit 5, timer-1 overflow is bit 2 and timer-0 overflow is bit 1. The other timer bits are ignored and read as zero. In the 2-bit general vectors, bit 0 is the external pin and bit 1 is pin change.
- R3: An interrupt is taken only at a clock edge where `insn_done` is 1, the global enable is 1 and an enabled flag is set. A flag whose enable or global enable is 0 stays pending and is taken once both are 1. `gie_clr` clears and `gie_set` sets the global enable.
- R4: Entry lasts four cycles. `take` is high in the first cycle. `push` is high in the first two cycles, one per byte of the 10-bit program counter. `vec_valid` is high in the fourth cycle with `vec_addr` holding the vector. `busy` is high in all four cycles.
- R5: Taking an interrupt clears the global enable and the flag of the served source in the same edge.
- R6: Writing a one to a bit of a flag-clear input clears that flag. Writing a zero leaves it unchanged.
- R7: If a flag is set by its event in the same edge as it is cleared, whether by a write or by being served, the flag ends up set.
- R8: A completing return instruction starts a four-cycle return sequence. `pop` is high in the first two cycles, and the global enable becomes 1 at the end of the sequence.
- R9: After the return sequence, exactly one instruction boundary passes without an interrupt being taken. A pending interrupt is taken at the second boundary.
- R10: After reset all flags, the global enable, `busy`, `take`, `push`, `pop` and `vec_valid` are 0.
- R11: While `busy` is 1, `insn_done` is ignored, but events still set their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | An instruction completes at this edge |
| reti_done | input | 1 | The completing instruction is a return-from-interrupt |
| gie_set | input | 1 | Software sets the global enable |
| gie_clr | input | 1 | Software clears the global enable |
| ext_evt | input | 1 | External pin event |
| pin_evt | input | 1 | Pin-change event |
| tmr_evt | input | 8 | Timer events, bits 6, 5, 2, 1 used |
| ext_en | input | 1 | External pin enable |
| pin_en | input | 1 | Pin-change enable |
| tmr_mask | input | 8 | Timer enables, same layout as `tmr_evt` |
| gen_w1c | input | 2 | Write-one-to-clear for the general flags |
| tmr_w1c | input | 8 | Write-one-to-clear for the timer flags |
| gie | output | 1 | Global enable state |
| gen_flags | output | 2 | General flags (bit 0 external, bit 1 pin change) |
| tmr_flags | output | 8 | Timer flags |
| take | output | 1 | First cycle of an entry sequence |
| push | output | 1 | Push one program-counter byte |
| pop | output | 1 | Pop one program-counter byte |
| vec_valid | output | 1 | Vector address valid, last entry cycle |
| vec_addr | output | 10 | Vector address of the served source |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
Two events can land on the same flag in one cycle: the clear caused by serving it (or by a software write) and a new event from its source. The bench raises the external event in the very cycle whose edge takes that source. It also raises a timer event together with a write-one-to-clear of the same bit. After the edge it reads the flag outputs and expects the flag to be set, because a new event must never be lost. The bench also raises an event while an entry sequence is running and confirms that the flag is latched and that no second `take` appears.

// File: rtl/irq_pkg.sv
// Package irq_pkg: shared constants and types of the interrupt controller.
// Source indices are ordered by priority; index i is served at vector i+1.
package irq_pkg;
    localparam int NSRC    = 6;
    localparam int SRC_EXT = 0;
    localparam int SRC_PIN = 1;
    localparam int SRC_T1A = 2;
    localparam int SRC_T1B = 3;
    localparam int SRC_T1O = 4;
    localparam int SRC_T0O = 5;

    // Timer register bit positions (software-visible layout)
    localparam int TB_T1A = 6;
    localparam int TB_T1B = 5;
    localparam int TB_T1O = 2;
    localparam int TB_T0O = 1;
    localparam int TMR_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_RETURN = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_flag_bank.sv
// Module irq_flag_bank: one sticky flag per source.
// Assumes set, write-one-to-clear and service-clear are single-cycle strobes.
// A set strobe overrides both clears in the same cycle, so no event is lost.
module irq_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] svc_clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: hold one pending request until it is cleared
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[i] <= 1'b0;
            else
                flags_o[i] <= set_i[i] | (flags_o[i] & ~w1c_i[i] & ~svc_clr_i[i]);
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module irq_prio_pick: fixed-priority selector, index 0 highest.
// Purely combinational; produces a one-hot grant and the vector (index+1).
module irq_prio_pick #(
    parameter int N     = 6,
    parameter int VEC_W = 10
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant_o[i]  = req_i[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req_i[i];
    end

    assign any_o = seen[N];

    // Purpose: encode the granted index into its vector address
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i])
                vec_o = VEC_W'(i + 1);
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
// Module irq_seq_fsm: entry/return sequencer and global-enable owner.
// Assumes insn_done marks the last cycle of each instruction and that
// reti_done is only meaningful together with insn_done.
module irq_seq_fsm #(
    parameter int ENTRY_CYC = 4,
    parameter int RET_CYC   = 4,
    parameter int PUSH_N    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_done,
    input  logic reti_done,
    input  logic req_any,
    input  logic gie_set,
    input  logic gie_clr,
    output logic accept_o,
    output logic gie_o,
    output logic take_o,
    output logic push_o,
    output logic pop_o,
    output logic vec_valid_o,
    output logic busy_o
);
    import irq_pkg::*;

    localparam int MAXC  = (ENTRY_CYC > RET_CYC) ? ENTRY_CYC : RET_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hold_q;
    logic             start_ret;
    logic             last_entry;
    logic             last_ret;

    // Purpose: decode boundary events and the final cycles of each sequence
    always_comb begin
        start_ret  = (state_q == ST_IDLE) && insn_done && reti_done;
        accept_o   = (state_q == ST_IDLE) && insn_done && !reti_done &&
                     req_any && gie_o && !hold_q;
        last_entry = (state_q == ST_ENTRY)  && (cnt_q == CNT_W'(ENTRY_CYC - 1));
        last_ret   = (state_q == ST_RETURN) && (cnt_q == CNT_W'(RET_CYC - 1));
    end

    // Purpose: advance the sequence state and its cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_ret)
                        state_q <= ST_RETURN;
                    else if (accept_o)
                        state_q <= ST_ENTRY;
                end
                ST_ENTRY: begin
                    if (last_entry) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RETURN: begin
                    if (last_ret) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Purpose: global enable, hardware entry/return beat software strobes
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_o <= 1'b0;
        else if (accept_o)
            gie_o <= 1'b0;
        else if (last_ret)
            gie_o <= 1'b1;
        else if (gie_clr)
            gie_o <= 1'b0;
        else if (gie_set)
            gie_o <= 1'b1;
    end

    // Purpose: block taking until one instruction has completed after return
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (last_ret)
            hold_q <= 1'b1;
        else if ((state_q == ST_IDLE) && insn_done)
            hold_q <= 1'b0;
    end

    assign take_o      = (state_q == ST_ENTRY) && (cnt_q == '0);
    assign push_o      = (state_q == ST_ENTRY) && (cnt_q < CNT_W'(PUSH_N));
    assign pop_o       = (state_q == ST_RETURN) && (cnt_q < CNT_W'(PUSH_N));
    assign vec_valid_o = last_entry;
    assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module irq_vector_ctrl: top of the vectored interrupt controller.
// Maps the software register layout onto priority-ordered sources, picks
// one request per boundary, latches its vector and clears its flag.
// Assumes all event and clear inputs are synchronous single-cycle strobes.
module irq_vector_ctrl #(
    parameter int PC_W      = 10,
    parameter int ENTRY_CYC = 4,
    parameter int RET_CYC   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     insn_done,
    input  logic                     reti_done,
    input  logic                     gie_set,
    input  logic                     gie_clr,
    input  logic                     ext_evt,
    input  logic                     pin_evt,
    input  logic [irq_pkg::TMR_W-1:0] tmr_evt,
    input  logic                     ext_en,
    input  logic                     pin_en,
    input  logic [irq_pkg::TMR_W-1:0] tmr_mask,
    input  logic [1:0]               gen_w1c,
    input  logic [irq_pkg::TMR_W-1:0] tmr_w1c,
    output logic                     gie,
    output logic [1:0]               gen_flags,
    output logic [irq_pkg::TMR_W-1:0] tmr_flags,
    output logic                     take,
    output logic                     push,
    output logic                     pop,
    output logic                     vec_valid,
    output logic [PC_W-1:0]          vec_addr,
    output logic                     busy
);
    import irq_pkg::*;

    localparam int PUSH_N = (PC_W + 7) / 8;

    logic [NSRC-1:0] src_set, src_en, src_w1c, src_flag, src_req;
    logic [NSRC-1:0] grant, svc_clr;
    logic            req_any, accept;
    logic [PC_W-1:0] pick_vec, vec_q;
    logic            unused_tmr;

    // Purpose: map register bit layout onto priority-ordered source indices
    always_comb begin
        src_set = '0;
        src_en  = '0;
        src_w1c = '0;
        src_set[SRC_EXT] = ext_evt;          src_en[SRC_EXT] = ext_en;
        src_set[SRC_PIN] = pin_evt;          src_en[SRC_PIN] = pin_en;
        src_set[SRC_T1A] = tmr_evt[TB_T1A];  src_en[SRC_T1A] = tmr_mask[TB_T1A];
        src_set[SRC_T1B] = tmr_evt[TB_T1B];  src_en[SRC_T1B] = tmr_mask[TB_T1B];
        src_set[SRC_T1O] = tmr_evt[TB_T1O];  src_en[SRC_T1O] = tmr_mask[TB_T1O];
        src_set[SRC_T0O] = tmr_evt[TB_T0O];  src_en[SRC_T0O] = tmr_mask[TB_T0O];
        src_w1c[SRC_EXT] = gen_w1c[0];
        src_w1c[SRC_PIN] = gen_w1c[1];
        src_w1c[SRC_T1A] = tmr_w1c[TB_T1A];
        src_w1c[SRC_T1B] = tmr_w1c[TB_T1B];
        src_w1c[SRC_T1O] = tmr_w1c[TB_T1O];
        src_w1c[SRC_T0O] = tmr_w1c[TB_T0O];
    end

    assign unused_tmr = ^{tmr_evt[7], tmr_evt[4], tmr_evt[3], tmr_evt[0],
                          tmr_mask[7], tmr_mask[4], tmr_mask[3], tmr_mask[0],
                          tmr_w1c[7], tmr_w1c[4], tmr_w1c[3], tmr_w1c[0]};

    assign src_req = src_flag & src_en;
    assign svc_clr = accept ? grant : '0;

    irq_flag_bank #(.N(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (src_set),
        .w1c_i     (src_w1c),
        .svc_clr_i (svc_clr),
        .flags_o   (src_flag)
    );

    irq_prio_pick #(.N(NSRC), .VEC_W(PC_W)) u_pick (
        .req_i   (src_req),
        .grant_o (grant),
        .any_o   (req_any),
        .vec_o   (pick_vec)
    );

    irq_seq_fsm #(
        .ENTRY_CYC (ENTRY_CYC),
        .RET_CYC   (RET_CYC),
        .PUSH_N    (PUSH_N)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done   (insn_done),
        .reti_done   (reti_done),
        .req_any     (req_any),
        .gie_set     (gie_set),
        .gie_clr     (gie_clr),
        .accept_o    (accept),
        .gie_o       (gie),
        .take_o      (take),
        .push_o      (push),
        .pop_o       (pop),
        .vec_valid_o (vec_valid),
        .busy_o      (busy)
    );

    // Purpose: capture the winning vector at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (accept)
            vec_q <= pick_vec;
    end

    assign vec_addr  = vec_q;
    assign gen_flags = {src_flag[SRC_PIN], src_flag[SRC_EXT]};

    // Purpose: rebuild the timer flag view, unused bits read zero
    always_comb begin
        tmr_flags         = '0;
        tmr_flags[TB_T1A] = src_flag[SRC_T1A];
        tmr_flags[TB_T1B] = src_flag[SRC_T1B];
        tmr_flags[TB_T1O] = src_flag[SRC_T1O];
        tmr_flags[TB_T0O] = src_flag[SRC_T0O];
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Module irq_vector_ctrl_chk: protocol checker bound to irq_vector_ctrl.
// Observes ports only.
module irq_vector_ctrl_chk #(
    parameter int PC_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            insn_done,
    input logic            ext_evt,
    input logic            gie,
    input logic [1:0]      gen_flags,
    input logic [7:0]      tmr_flags,
    input logic            take,
    input logic            push,
    input logic            pop,
    input logic            vec_valid,
    input logic [PC_W-1:0] vec_addr,
    input logic            busy
);
    assert_take_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(gie) && $past(insn_done) && !$past(busy)));

    assert_gie_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !gie);

    assert_entry_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy && !take));

    assert_vec_in_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (busy && !take && !push));

    assert_push_pop_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_flags & 8'b1001_1001) == 8'h00);

    assert_ext_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec_addr == PC_W'(1)) |-> (!gen_flags[0] || $past(ext_evt)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .ext_evt   (ext_evt),
    .gie       (gie),
    .gen_flags (gen_flags),
    .tmr_flags (tmr_flags),
    .take      (take),
    .push      (push),
    .pop       (pop),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .busy      (busy)
);

// File: tb/sim_irq_vector_ctrl.sv
// Directed bench for irq_vector_ctrl: one task per scenario.
module sim_irq_vector_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done = 1'b0, reti_done = 1'b0, gie_set = 1'b0, gie_clr = 1'b0;
    logic       ext_evt = 1'b0, pin_evt = 1'b0, ext_en = 1'b0, pin_en = 1'b0;
    logic [7:0] tmr_evt = '0, tmr_mask = '0, tmr_w1c = '0;
    logic [1:0] gen_w1c = '0;
    logic       gie, take, push, pop, vec_valid, busy;
    logic [1:0] gen_flags;
    logic [7:0] tmr_flags;
    logic [9:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reti_done(reti_done),
        .gie_set(gie_set), .gie_clr(gie_clr), .ext_evt(ext_evt), .pin_evt(pin_evt),
        .tmr_evt(tmr_evt), .ext_en(ext_en), .pin_en(pin_en), .tmr_mask(tmr_mask),
        .gen_w1c(gen_w1c), .tmr_w1c(tmr_w1c), .gie(gie), .gen_flags(gen_flags),
        .tmr_flags(tmr_flags), .take(take), .push(push), .pop(pop),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        {insn_done, reti_done, gie_set, gie_clr, ext_evt, pin_evt, ext_en, pin_en} = '0;
        tmr_evt = '0; tmr_mask = '0; tmr_w1c = '0; gen_w1c = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_take;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (take) break;
        end
        chk("R3 take seen", int'(take), 1);
    endtask

    // Called at the negedge where take was first seen
    task automatic entry_seq(input int vec);
        chk("R4 push cycle0", int'(push), 1);
        chk("R4 busy", int'(busy), 1);
        chk("R5 gie cleared", int'(gie), 0);
        @(negedge clk);
        chk("R4 take one cycle", int'(take), 0);
        chk("R4 push cycle1", int'(push), 1);
        @(negedge clk);
        chk("R4 push done", int'(push), 0);
        chk("R4 vec early", int'(vec_valid), 0);
        @(negedge clk);
        chk("R4 vec_valid", int'(vec_valid), 1);
        chk("R2 vec_addr", int'(vec_addr), vec);
        @(negedge clk);
        chk("R4 busy end", int'(busy), 0);
    endtask

    // Return sequence; if next_vec != 0 expects that vector after one instruction
    task automatic reti_then(input int next_vec);
        int n;
        insn_done = 1'b1; reti_done = 1'b1;
        @(negedge clk);
        reti_done = 1'b0;
        chk("R8 pop0", int'(pop), 1);
        chk("R8 busy", int'(busy), 1);
        @(negedge clk);
        chk("R8 pop1", int'(pop), 1);
        @(negedge clk);
        chk("R8 pop done", int'(pop), 0);
        @(negedge clk);
        chk("R8 gie still low", int'(gie), 0);
        @(negedge clk);
        chk("R8 return end", int'(busy), 0);
        chk("R8 gie set", int'(gie), 1);
        if (next_vec != 0) begin
            n = 0;
            for (int k = 0; k < 10; k++) begin
                if (take) break;
                if (!busy) n++;
                @(negedge clk);
            end
            // one boundary untaken, the second one takes
            chk("R9 boundaries before take", n, 2);
            entry_seq(next_vec);
        end else begin
            repeat (3) begin
                @(negedge clk);
                chk("R9 nothing pending", int'(take), 0);
            end
        end
    endtask

    task automatic t_reset;
        do_reset();
        chk("R10 gie", int'(gie), 0);
        chk("R10 flags", int'({gen_flags, tmr_flags}), 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 strobes", int'({take, push, pop, vec_valid}), 0);
    endtask

    task automatic t_masked_pending;
        do_reset();
        gie_set = 1'b1; tmr_evt = 8'h02;
        @(negedge clk);
        gie_set = 1'b0; tmr_evt = 8'h00;
        gie_clr = 1'b1;
        @(negedge clk);
        gie_clr = 1'b0;
        chk("R3 gie_clr", int'(gie), 0);
        gie_set = 1'b1;
        @(negedge clk);
        gie_set = 1'b0;
        chk("R3 gie_set", int'(gie), 1);
        insn_done = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R3 masked no take", int'(take), 0);
        end
        chk("R3 masked flag pending", int'(tmr_flags), 8'h02);
        insn_done = 1'b0; tmr_mask = 8'h02;
        repeat (3) begin
            @(negedge clk);
            chk("R3 no boundary no take", int'(take), 0);
        end
        insn_done = 1'b1;
        wait_take();
        chk("R5 flag served", int'(tmr_flags), 0);
        entry_seq(6);
    endtask

    task automatic t_priority;
        do_reset();
        ext_en = 1'b1; pin_en = 1'b1; tmr_mask = 8'hFF;
        ext_evt = 1'b1; pin_evt = 1'b1; tmr_evt = 8'hFF;
        @(negedge clk);
        ext_evt = 1'b0; pin_evt = 1'b0; tmr_evt = 8'h00;
        chk("R2 general flags", int'(gen_flags), 2'b11);
        chk("R2 timer flags unused zero", int'(tmr_flags), 8'h66);
        insn_done = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk("R3 gie low no take", int'(take), 0);
        end
        gie_set = 1'b1;
        @(negedge clk);
        gie_set = 1'b0;
        wait_take();
        chk("R1 others pending gen", int'(gen_flags), 2'b10);
        chk("R1 others pending tmr", int'(tmr_flags), 8'h66);
        entry_seq(1);
        for (int v = 2; v <= 6; v++) reti_then(v);
        chk("R1 all served", int'({gen_flags, tmr_flags}), 0);
        reti_then(0);
        insn_done = 1'b0;
    endtask

    task automatic t_w1c;
        do_reset();
        ext_evt = 1'b1; pin_evt = 1'b1; tmr_evt = 8'h66;
        @(negedge clk);
        ext_evt = 1'b0; pin_evt = 1'b0; tmr_evt = 8'h00;
        gen_w1c = 2'b01; tmr_w1c = 8'h42;
        @(negedge clk);
        gen_w1c = 2'b00; tmr_w1c = 8'h00;
        chk("R6 gen partial clear", int'(gen_flags), 2'b10);
        chk("R6 tmr partial clear", int'(tmr_flags), 8'h24);
        gen_w1c = 2'b11; tmr_w1c = 8'hFF;
        @(negedge clk);
        gen_w1c = 2'b00; tmr_w1c = 8'h00;
        chk("R6 all clear", int'({gen_flags, tmr_flags}), 0);
    endtask

    task automatic t_collide;
        do_reset();
        ext_en = 1'b1; ext_evt = 1'b1; gie_set = 1'b1;
        @(negedge clk);
        gie_set = 1'b0;
        insn_done = 1'b1;
        @(negedge clk);
        ext_evt = 1'b0;
        chk("R7 take with event", int'(take), 1);
        chk("R7 served flag re-set", int'(gen_flags[0]), 1);
        entry_seq(1);
        tmr_evt = 8'h40; tmr_w1c = 8'h40;
        @(negedge clk);
        tmr_evt = 8'h00; tmr_w1c = 8'h00;
        chk("R7 w1c with event", int'(tmr_flags), 8'h40);
        tmr_w1c = 8'h40;
        @(negedge clk);
        tmr_w1c = 8'h00;
        chk("R6 single clear", int'(tmr_flags), 0);
        insn_done = 1'b0;
    endtask

    task automatic t_busy_ignore;
        do_reset();
        tmr_mask = 8'h04; tmr_evt = 8'h04; gie_set = 1'b1;
        @(negedge clk);
        tmr_evt = 8'h00; gie_set = 1'b0;
        insn_done = 1'b1;
        wait_take();
        chk("R2 t1 overflow vector", int'(vec_addr), 5);
        pin_en = 1'b1; pin_evt = 1'b1; gie_set = 1'b1;
        @(negedge clk);
        pin_evt = 1'b0; gie_set = 1'b0;
        chk("R11 busy", int'(busy), 1);
        chk("R11 event latched", int'(gen_flags[1]), 1);
        chk("R11 no retake", int'(take), 0);
        repeat (2) begin
            @(negedge clk);
            chk("R11 no retake", int'(take), 0);
        end
        @(negedge clk);
        chk("R11 entry done", int'(busy), 0);
        insn_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_masked_pending();
        t_priority();
        t_w1c();
        t_collide();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule